// File: doc/BRIEF.md
# Wide Mantissa Align-Add-Normalize Unit

This unit is the addition stage that follows the multiplier in a fused multiply-add datapath. It accepts a 128-bit product significand whose leading one already sits at bit 126, together with the product's signed exponent and sign. It also accepts a 53-bit addend significand carrying its hidden bit at bit 52, plus the addend's signed exponent and sign. A flag marks a zero addend, and a second flag selects round-toward-minus-infinity for the sign of an exact zero.

The addend is widened so that its hidden bit lines up with the product's leading one. The operand with the smaller exponent is then shifted right, and every bit that falls off is collected into a sticky bit. The two operands are added when their signs agree. When the signs differ, the smaller magnitude is taken from the larger one and the result keeps the sign of the larger operand. The result is renormalized to bit 126. A last right shift with sticky delivers a 56-bit significand made of 53 bits and 3 rounding bits. Rounding and packing happen downstream.

The unit is a two-stage pipeline. Accepted inputs are marked by `in_valid` and completed results by `out_valid`. A new operation can be issued on every clock.

Top module: `wide_align_add_norm`

## Requirements
- R1: While reset is active, and right after it, `out_valid` is low.
- R2: A result appears on the outputs, with `out_valid` high for one cycle, exactly two rising edges after the edge that captures `in_valid`. Without `in_valid`, `out_valid` stays low two edges later.
- R3: The addend is treated as its significand shifted left by 74, which puts its hidden bit at bit 126. The operand with the smaller exponent is shifted right by the exponent difference, and the discarded bits are ORed into bit 0. A difference of 128 or more reduces that operand to a lone sticky bit. The working exponent becomes the larger of the two.
- R4: When the signs match, the magnitudes are added. A carry into bit 127 causes a 1-bit sticky right shift and raises the exponent by one.
- R5: When the signs differ, the smaller magnitude is subtracted from the larger. The result carries the sign of the larger magnitude.
- R6: An exact zero difference gives `out_sig` = 0 and `out_exp` = 0. `out_neg` then equals `round_down` (1 = round toward minus infinity).
- R7: A nonzero difference is renormalized to bit 126 and the exponent is lowered by the shift. If bits 127:64 are zero, the value is first shifted left by 63 when bit 63 is set, or by 64 otherwise. A leading-zero count over bits 126:64 then finishes the shift.
- R8: The output significand is the normalized value shifted right by 71 with sticky: `out_sig[55:1]` = bits 126:72, and `out_sig[0]` = OR of bits 71:0. Any nonzero result therefore has `out_sig[55]` set.
- R9: When `add_zero` is 1, `add_sig`, `add_exp` and `add_neg` have no effect. The output is the product shifted right by 71 with sticky, with the product's exponent and sign.
- R10: The output data registers keep their values during any cycle in which no result completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| prod_sig | input | 128 | Product significand, leading one at bit 126 |
| prod_exp | input | EXP_W | Product exponent, two's complement |
| prod_neg | input | 1 | Product sign (1 = negative) |
| add_sig | input | MANT_W | Addend significand, hidden bit at MANT_W-1 |
| add_exp | input | EXP_W | Addend exponent, two's complement |
| add_neg | input | 1 | Addend sign (1 = negative) |
| add_zero | input | 1 | Addend is zero |
| round_down | input | 1 | Rounding toward minus infinity is active |
| out_valid | output | 1 | Result valid |
| out_sig | output | MANT_W+3 | Normalized significand with 3 rounding bits |
| out_exp | output | EXP_W | Result exponent, two's complement |
| out_neg | output | 1 | Result sign |

## Verification
The bench builds the unit with its default parameters: a 13-bit exponent and a 53-bit addend significand, which is the double-precision shape. With a 13-bit exponent, differences of several hundred and of exactly 127 and 128 can be expressed, so both the partial sticky shift and the collapse to a single sticky bit are reached. Because the widened addend occupies bits 126:74, cancellation down into the low half of the word can only come from product low bits. The vectors therefore set such bits on purpose, which drives both the 63-bit and the 64-bit pre-shift branches.

// File: rtl/wan_pkg.sv
package wan_pkg;

  localparam int WIDE_W   = 128;
  localparam int SH_W     = $clog2(WIDE_W);
  localparam int LEAD_BIT = WIDE_W - 2;

  // Right shift that folds every discarded bit into bit 0. When far is
  // set the shift covers the whole word and only the sticky bit survives.
  function automatic logic [WIDE_W-1:0] sticky_shr(
    input logic [WIDE_W-1:0] v,
    input logic [SH_W-1:0]   amt,
    input logic              far
  );
    logic [WIDE_W-1:0] r;
    logic [WIDE_W-1:0] lost_mask;
    lost_mask = ~({WIDE_W{1'b1}} << amt);
    r         = v >> amt;
    if (far) begin
      r = {{(WIDE_W-1){1'b0}}, |v};
    end else begin
      r[0] = r[0] | (|(v & lost_mask));
    end
    return r;
  endfunction

endpackage

// File: rtl/wan_align.sv
module wan_align
  import wan_pkg::*;
#(
  parameter int EXP_W  = 13,
  parameter int MANT_W = 53
) (
  input  logic [WIDE_W-1:0] prod_sig,
  input  logic [EXP_W-1:0]  prod_exp,
  input  logic [MANT_W-1:0] add_sig,
  input  logic [EXP_W-1:0]  add_exp,
  input  logic              add_zero,
  output logic [WIDE_W-1:0] al_prod,
  output logic [WIDE_W-1:0] al_add,
  output logic [EXP_W-1:0]  al_exp
);

  localparam int ADD_POS = LEAD_BIT - (MANT_W - 1);

  logic [WIDE_W-1:0]      add_wide;
  logic signed [EXP_W:0]  ediff;
  logic [EXP_W:0]         dmag;
  logic                   far;
  logic [SH_W-1:0]        amt;

  always_comb begin
    add_wide = WIDE_W'(add_sig) << ADD_POS;
    ediff    = $signed({prod_exp[EXP_W-1], prod_exp}) -
               $signed({add_exp[EXP_W-1], add_exp});
    dmag     = ediff[EXP_W] ? $unsigned(-ediff) : $unsigned(ediff);
    far      = |(dmag >> SH_W);
    amt      = dmag[SH_W-1:0];

    if (add_zero) begin
      al_prod = prod_sig;
      al_add  = '0;
      al_exp  = prod_exp;
    end else if (!ediff[EXP_W]) begin
      al_prod = prod_sig;
      al_add  = sticky_shr(add_wide, amt, far);
      al_exp  = prod_exp;
    end else begin
      al_prod = sticky_shr(prod_sig, amt, far);
      al_add  = add_wide;
      al_exp  = add_exp;
    end
  end

endmodule

// File: rtl/wan_addsub.sv
module wan_addsub
  import wan_pkg::*;
(
  input  logic [WIDE_W-1:0] al_prod,
  input  logic [WIDE_W-1:0] al_add,
  input  logic              prod_neg,
  input  logic              add_neg,
  input  logic              add_zero,
  output logic [WIDE_W-1:0] raw,
  output logic              raw_neg,
  output logic              cancel
);

  logic eff_sub;
  logic add_ge;

  always_comb begin
    eff_sub = (prod_neg ^ add_neg) & ~add_zero;
    add_ge  = (al_add >= al_prod);
    if (!eff_sub) begin
      raw     = al_prod + al_add;
      raw_neg = prod_neg;
    end else if (add_ge) begin
      raw     = al_add - al_prod;
      raw_neg = add_neg;
    end else begin
      raw     = al_prod - al_add;
      raw_neg = prod_neg;
    end
    cancel = eff_sub & (raw == '0);
  end

endmodule

// File: rtl/wan_norm.sv
module wan_norm
  import wan_pkg::*;
#(
  parameter int EXP_W = 13,
  parameter int OUT_W = 56
) (
  input  logic [WIDE_W-1:0] raw,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [OUT_W-1:0]  nsig,
  output logic [EXP_W-1:0]  nexp
);

  localparam int HALF   = WIDE_W / 2;
  localparam int HI_W   = WIDE_W - 1 - HALF;
  localparam int CNT_W  = $clog2(HI_W + 1);
  localparam int FIN_SH = LEAD_BIT - (OUT_W - 1);

  logic [WIDE_W-2:0] p;
  logic [WIDE_W-2:0] nv;
  logic [CNT_W-1:0]  lz;
  logic              found;
  logic [EXP_W-1:0]  e;

  always_comb begin
    p     = raw[WIDE_W-2:0];
    e     = exp_in;
    lz    = '0;
    found = 1'b0;
    if (raw[WIDE_W-1]) begin
      // carry out of the add: one place right, sticky kept
      nv = {raw[WIDE_W-1:2], raw[1] | raw[0]};
      e  = exp_in + EXP_W'(1);
    end else begin
      if (p[WIDE_W-2:HALF] == '0) begin
        if (p[HALF-1]) begin
          p = p << (HALF - 1);
          e = e - EXP_W'(HALF - 1);
        end else begin
          p = p << HALF;
          e = e - EXP_W'(HALF);
        end
      end
      for (int i = HI_W - 1; i >= 0; i--) begin
        if (!found && p[HALF+i]) begin
          found = 1'b1;
          lz    = CNT_W'(HI_W - 1 - i);
        end
      end
      nv = p << lz;
      e  = e - EXP_W'(lz);
    end
    nsig = {nv[WIDE_W-2 -: OUT_W-1], nv[FIN_SH] | (|nv[FIN_SH-1:0])};
    nexp = e;
  end

endmodule

// File: rtl/wide_align_add_norm.sv
module wide_align_add_norm
  import wan_pkg::*;
#(
  parameter int EXP_W  = 13,
  parameter int MANT_W = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [127:0]      prod_sig,
  input  logic [EXP_W-1:0]  prod_exp,
  input  logic              prod_neg,
  input  logic [MANT_W-1:0] add_sig,
  input  logic [EXP_W-1:0]  add_exp,
  input  logic              add_neg,
  input  logic              add_zero,
  input  logic              round_down,
  output logic              out_valid,
  output logic [MANT_W+2:0] out_sig,
  output logic [EXP_W-1:0]  out_exp,
  output logic              out_neg
);

  localparam int OUT_W = MANT_W + 3;

  // stage 1: align and add
  logic [WIDE_W-1:0] al_prod, al_add, raw;
  logic [EXP_W-1:0]  al_exp;
  logic              raw_neg, cancel;

  logic              s1_valid;
  logic [WIDE_W-1:0] s1_raw;
  logic [EXP_W-1:0]  s1_exp;
  logic              s1_neg, s1_zero, s1_rdn;

  // stage 2: normalize and final shift
  logic [OUT_W-1:0]  n_sig;
  logic [EXP_W-1:0]  n_exp;
  logic [OUT_W-1:0]  o_sig_d;
  logic [EXP_W-1:0]  o_exp_d;
  logic              o_neg_d;

  wan_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_align (
    .prod_sig (prod_sig),
    .prod_exp (prod_exp),
    .add_sig  (add_sig),
    .add_exp  (add_exp),
    .add_zero (add_zero),
    .al_prod  (al_prod),
    .al_add   (al_add),
    .al_exp   (al_exp)
  );

  wan_addsub i_addsub (
    .al_prod  (al_prod),
    .al_add   (al_add),
    .prod_neg (prod_neg),
    .add_neg  (add_neg),
    .add_zero (add_zero),
    .raw      (raw),
    .raw_neg  (raw_neg),
    .cancel   (cancel)
  );

  wan_norm #(.EXP_W(EXP_W), .OUT_W(OUT_W)) i_norm (
    .raw    (s1_raw),
    .exp_in (s1_exp),
    .nsig   (n_sig),
    .nexp   (n_exp)
  );

  always_comb begin
    o_sig_d = s1_zero ? '0 : n_sig;
    o_exp_d = s1_zero ? '0 : n_exp;
    o_neg_d = s1_zero ? s1_rdn : s1_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_raw  <= raw;
      s1_exp  <= al_exp;
      s1_neg  <= raw_neg;
      s1_zero <= cancel;
      s1_rdn  <= round_down;
    end
    if (s1_valid) begin
      out_sig <= o_sig_d;
      out_exp <= o_exp_d;
      out_neg <= o_neg_d;
    end
  end

endmodule

// File: rtl/wide_align_add_norm_chk.sv
module wide_align_add_norm_chk #(
  parameter int EXP_W  = 13,
  parameter int MANT_W = 53
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [EXP_W-1:0]  prod_exp,
  input logic              prod_neg,
  input logic              add_zero,
  input logic              round_down,
  input logic              out_valid,
  input logic [MANT_W+2:0] out_sig,
  input logic [EXP_W-1:0]  out_exp,
  input logic              out_neg
);

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  a_r6_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sig == '0) |-> (out_exp == '0 && out_neg == $past(round_down, 2)));

  a_r8_lead_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sig != '0) |-> out_sig[MANT_W+2]);

  a_r9_zero_addend: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(add_zero, 2)) |->
      (out_exp == $past(prod_exp, 2) && out_neg == $past(prod_neg, 2)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid, 2) |-> ($stable(out_sig) && $stable(out_exp) && $stable(out_neg)));

endmodule

bind wide_align_add_norm wide_align_add_norm_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .prod_exp   (prod_exp),
  .prod_neg   (prod_neg),
  .add_zero   (add_zero),
  .round_down (round_down),
  .out_valid  (out_valid),
  .out_sig    (out_sig),
  .out_exp    (out_exp),
  .out_neg    (out_neg)
);

// File: tb/test_wide_align_add_norm.sv
`timescale 1ns/1ps
module test_wide_align_add_norm;

  localparam int EW = 13;
  localparam int MW = 53;
  localparam int OW = MW + 3;
  localparam int NV = 12;

  typedef struct packed {
    logic [127:0]  ps;
    logic [EW-1:0] pe;
    logic          pn;
    logic [MW-1:0] as;
    logic [EW-1:0] ae;
    logic          an;
    logic          az;
    logic          rd;
  } stim_t;

  localparam stim_t VEC [NV] = '{
    '{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd0,     1'b0, 53'h10000000000000, 13'd0,    1'b0, 1'b0, 1'b0},
    '{128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 13'd3,     1'b1, 53'h1FFFFFFFFFFFFF, 13'd3,    1'b1, 1'b0, 1'b0},
    '{128'h5555_5555_5555_5555_5555_5555_5555_5555, 13'd10,    1'b0, 53'h1ABCDEF0123456, -13'sd20, 1'b0, 1'b0, 1'b0},
    '{128'h4000_0000_0000_0001_0000_0000_0000_0000, 13'd5,     1'b0, 53'h10000000000001, 13'd5,    1'b1, 1'b0, 1'b0},
    '{128'h6789_ABCD_EF01_2345_6789_ABCD_EF01_2345, -13'sd1000, 1'b1, 53'h15555555555555, 13'd500,  1'b0, 1'b0, 1'b0},
    '{128'h4C00_0000_0000_0000_0000_0000_0000_00FF, 13'd900,   1'b0, 53'h1FFFFFFFFFFFFF, -13'sd300, 1'b1, 1'b0, 1'b0},
    '{128'h4000_0000_0000_0000_8000_0000_0000_0001, -13'sd2,   1'b1, 53'h10000000000000, -13'sd2,  1'b0, 1'b0, 1'b0},
    '{128'h4123_4567_89AB_CDEF_0000_0000_0000_0000, 13'd7,     1'b0, 53'h1048D159E26AF3, 13'd7,    1'b1, 1'b0, 1'b0},
    '{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd44,    1'b0, 53'h10000000000000, 13'd44,   1'b1, 1'b0, 1'b1},
    '{128'h5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A, 13'd12,    1'b1, 53'h1F0F0F0F0F0F0F, 13'd900,  1'b0, 1'b1, 1'b0},
    '{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd0,     1'b0, 53'h1F0F0F0F0F0F0F, 13'd128,  1'b0, 1'b0, 1'b0},
    '{128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 13'd127,   1'b0, 53'h10000000000000, 13'd0,    1'b1, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [127:0]      prod_sig;
  logic [EW-1:0]     prod_exp;
  logic              prod_neg;
  logic [MW-1:0]     add_sig;
  logic [EW-1:0]     add_exp;
  logic              add_neg;
  logic              add_zero;
  logic              round_down;
  logic              out_valid;
  logic [OW-1:0]     out_sig;
  logic [EW-1:0]     out_exp;
  logic              out_neg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wide_align_add_norm #(.EXP_W(EW), .MANT_W(MW)) i_wide_align_add_norm (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .prod_sig (prod_sig), .prod_exp (prod_exp), .prod_neg (prod_neg),
    .add_sig (add_sig), .add_exp (add_exp), .add_neg (add_neg),
    .add_zero (add_zero), .round_down (round_down),
    .out_valid (out_valid), .out_sig (out_sig), .out_exp (out_exp), .out_neg (out_neg)
  );

  function automatic logic [127:0] m_shr(logic [127:0] v, int n);
    logic st = 1'b0;
    for (int i = 0; i < n && i < 130; i++) begin
      st = st | v[0];
      v  = v >> 1;
    end
    v[0] = v[0] | st;
    return v;
  endfunction

  // reference result {neg, exp, sig} built from the requirements
  function automatic logic [OW+EW:0] model(stim_t s);
    logic [127:0] p, a, w;
    int e, pe, ae;
    logic ng;
    pe = int'($signed(s.pe));
    ae = int'($signed(s.ae));
    p  = s.ps;
    if (s.az) begin
      w = p; e = pe; ng = s.pn;
    end else begin
      a = {75'b0, s.as} << 74;
      if (pe >= ae) begin a = m_shr(a, pe - ae); e = pe; end
      else          begin p = m_shr(p, ae - pe); e = ae; end
      if (s.pn == s.an) begin
        w = p + a; ng = s.pn;
        if (w[127]) begin w = m_shr(w, 1); e = e + 1; end
      end else begin
        if (p > a) begin w = p - a; ng = s.pn; end
        else       begin w = a - p; ng = s.an; end
        if (w == '0) return {s.rd, {EW{1'b0}}, {OW{1'b0}}};
        while (!w[126]) begin w = w << 1; e = e - 1; end
      end
    end
    w = m_shr(w, 71);
    return {ng, e[EW-1:0], w[OW-1:0]};
  endfunction

  function automatic logic [OW+EW:0] outs();
    return {out_neg, out_exp, out_sig};
  endfunction

  task automatic chk(string tag, logic [OW+EW:0] act, logic [OW+EW:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(stim_t s);
    prod_sig = s.ps; prod_exp = s.pe; prod_neg = s.pn;
    add_sig = s.as; add_exp = s.ae; add_neg = s.an;
    add_zero = s.az; round_down = s.rd;
    in_valid = 1'b1;
  endtask

  // single issue: result visible two negedges after driving, then held
  task automatic run1(stim_t s, string tag, logic [OW+EW:0] exp);
    logic [OW+EW:0] seen;
    drive(s);
    @(negedge clk) in_valid = 1'b0;
    @(negedge clk);
    chk(tag, outs(), exp);
    chk({tag, " R2 valid"}, (OW+EW+1)'(out_valid), (OW+EW+1)'(1));
    seen = outs();
    @(negedge clk);
    chk({tag, " R10 hold"}, outs(), seen);
    chk({tag, " R2 single pulse"}, (OW+EW+1)'(out_valid), '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    prod_sig = '0; prod_exp = '0; prod_neg = 1'b0;
    add_sig = '0; add_exp = '0; add_neg = 1'b0; add_zero = 1'b0; round_down = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset idle", (OW+EW+1)'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", (OW+EW+1)'(out_valid), '0);

    // back-to-back stream through the table, checked against the model
    for (int i = 0; i < NV + 2; i++) begin
      if (i < NV) drive(VEC[i]);
      else        in_valid = 1'b0;
      if (i >= 2) begin
        chk("R2 stream valid", (OW+EW+1)'(out_valid), (OW+EW+1)'(1));
        chk("R3/R4/R5/R6/R7/R8/R9 table", outs(), model(VEC[i-2]));
      end
      @(negedge clk);
    end
    chk("R2 idle after stream", (OW+EW+1)'(out_valid), '0);

    // R4: 1.0 + 1.0 carries into bit 127
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd0, 1'b0,
           53'h10000000000000, 13'd0, 1'b0, 1'b0, 1'b0},
         "R4 carry", {1'b0, 13'd1, 56'h80_0000_0000_0000});
    // R6: exact cancellation, both rounding senses
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd9, 1'b0,
           53'h10000000000000, 13'd9, 1'b1, 1'b0, 1'b1},
         "R6 zero rdn", {1'b1, 13'd0, 56'h0});
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd9, 1'b1,
           53'h10000000000000, 13'd9, 1'b0, 1'b0, 1'b0},
         "R6 zero near", {1'b0, 13'd0, 56'h0});
    // R3/R5: product 200 below addend collapses to sticky, addend sign wins
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0000, 13'd0, 1'b0,
           53'h10000000000000, 13'd200, 1'b1, 1'b0, 1'b0},
         "R3 R5 far sticky", {1'b1, 13'd199, 56'hFF_FFFF_FFFF_FFFF});
    // R7: 63-place pre-shift, product sign kept (R5)
    run1('{128'h4000_0000_0000_0000_8000_0000_0000_0000, 13'd0, 1'b0,
           53'h10000000000000, 13'd0, 1'b1, 1'b0, 1'b0},
         "R7 preshift63 R5", {1'b0, 13'h1FC1, 56'h80_0000_0000_0000});
    // R7: 64-place pre-shift then count of 52
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0400, 13'd0, 1'b1,
           53'h10000000000000, 13'd0, 1'b0, 1'b0, 1'b0},
         "R7 preshift64", {1'b1, 13'h1F8C, 56'h80_0000_0000_0000});
    // R9 and R8: zero addend, two different addend field values
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0001, 13'd5, 1'b1,
           53'h1FFFFFFFFFFFFF, 13'd5, 1'b0, 1'b1, 1'b0},
         "R9 R8 zero addend a", {1'b1, 13'd5, 56'h80_0000_0000_0001});
    run1('{128'h4000_0000_0000_0000_0000_0000_0000_0001, 13'd5, 1'b1,
           53'h10000000000000, 13'd4000, 1'b1, 1'b1, 1'b1},
         "R9 R8 zero addend b", {1'b1, 13'd5, 56'h80_0000_0000_0001});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule